// File: doc/BRIEF.md
# First-Erroneous-Bit Histogram Collector

This block supports a direct measurement of converter resolution. For each conversion cycle of each sample, a bench or test harness presents the converter's long-word estimate together with the exact value of the input sample. The block takes the absolute difference of the two words and counts the zeros above its highest set bit, which is the number of leading bits the estimate got right. It then adds one to a histogram bin selected by the cycle index and that position.

For every cycle index the block also keeps the smallest position seen so far. The sharp lower edge of the distribution is the direct estimate of effective resolution at that cycle. A registered read port returns any bin count, and the minimum for the addressed cycle, so the histogram can be read out after a run. A clear input restarts the collection. Stimulus generation and statistics are left to the surrounding test environment.

Top module: `feb_hist`

## Requirements
- R1: The error word is |inEstimate − inReference|, with both inputs taken as unsigned WORD_W-bit values, whichever of the two is larger.
- R2: The bin position is the number of zero bits above the highest set bit of the error word, counted from the MSB, so an error with its MSB set gives position 0. A zero error word gives position WORD_W.
- R3: Each sample that is accepted adds exactly one to the bin [inCycle][position]. The bin changes on the second rising edge after the sample is presented. Samples presented on consecutive cycles are all counted.
- R4: Bin counters are 16 bits wide and saturate at 65535. They never wrap.
- R5: rdMin reports the lowest position counted for the addressed cycle since the last clear or reset, and WORD_W if that cycle has none.
- R6: A high clear zeroes every bin and sets every minimum to WORD_W. A sample presented together with clear is dropped. A sample presented one cycle before clear, whose bin update falls on the clear edge, is also dropped.
- R7: A sample whose inCycle is CYC_N or greater is ignored and changes no bin and no minimum.
- R8: rdCount and rdMin are registered one cycle after rdCycle and rdPos. An rdCycle of CYC_N or more, or an rdPos above WORD_W, reads a count of 0. An rdCycle of CYC_N or more reads a minimum of WORD_W.
- R9: After reset every bin reads 0 and every minimum reads WORD_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| clear | input | 1 | Synchronous clear of all bins and minima |
| inValid | input | 1 | Sample strobe |
| inCycle | input | CYC_W | Conversion cycle index of the sample |
| inEstimate | input | WORD_W | Converter estimate at that cycle |
| inReference | input | WORD_W | Exact input value |
| rdCycle | input | CYC_W | Read address, cycle index |
| rdPos | input | POS_W | Read address, position |
| rdCount | output | 16 | Count of the addressed bin |
| rdMin | output | POS_W | Lowest position seen for the addressed cycle |

## Verification
The assertions assume that between clears only one bin can grow per cycle. They also assume that a read address held steady for two cycles sees a count that grows by at most one and a minimum that only falls. Both hold only while the collection runs without a clear in the window, so every such property leaves out clear edges. The stimulus changes read addresses only between sample bursts, and it pulses clear on its own or together with samples that must be dropped. A near-exhaustive sweep of every estimate and reference pair for a 4-bit word over all cycle indices, including one that is out of range, is compared with a histogram computed arithmetically in the bench.

// File: rtl/feb_hist_pkg.sv
package feb_hist_pkg;
  localparam int CNT_W = 16;

  typedef struct packed {
    logic capture;
    logic update;
    logic clearAll;
  } febStrobeT;
endpackage

// File: rtl/feb_hist_ctrl.sv
module feb_hist_ctrl
  import feb_hist_pkg::*;
#(
  parameter int CYC_N = 50,
  parameter int CYC_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             inValid,
  input  logic [CYC_W-1:0] inCycle,
  output febStrobeT        strobe
);
  localparam logic [CYC_W:0] CYC_LIM = (CYC_W+1)'(CYC_N);

  logic inRange;
  logic pendValid;

  // Cycle indices beyond the table are dropped here.
  assign inRange = {1'b0, inCycle} < CYC_LIM;

  always_comb begin
    strobe.clearAll = clear;
    strobe.capture  = inValid && inRange && !clear;
    strobe.update   = pendValid && !clear;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pendValid <= 1'b0;
    else        pendValid <= strobe.capture;
  end
endmodule

// File: rtl/feb_hist_dp.sv
module feb_hist_dp
  import feb_hist_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CYC_N  = 50,
  parameter int CYC_W  = 6,
  parameter int POS_W  = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  febStrobeT         strobe,
  input  logic [CYC_W-1:0]  inCycle,
  input  logic [WORD_W-1:0] inEstimate,
  input  logic [WORD_W-1:0] inReference,
  input  logic [CYC_W-1:0]  rdCycle,
  input  logic [POS_W-1:0]  rdPos,
  output logic [CNT_W-1:0]  rdCount,
  output logic [POS_W-1:0]  rdMin
);
  localparam int NBIN = WORD_W + 1;
  localparam logic [POS_W-1:0] POS_EMPTY = POS_W'(WORD_W);

  logic [WORD_W-1:0] absErr;
  logic [POS_W-1:0]  errPos;
  logic [CYC_W-1:0]  pendCycle;
  logic [POS_W-1:0]  pendPos;

  logic [CYC_N-1:0][NBIN-1:0][CNT_W-1:0] binFlat;
  logic [CYC_N-1:0][POS_W-1:0]           minFlat;

  // Absolute error and leading-zero count.
  always_comb begin
    if (inEstimate >= inReference) absErr = inEstimate - inReference;
    else                           absErr = inReference - inEstimate;
  end

  always_comb begin
    errPos = POS_EMPTY;
    for (int i = 0; i < WORD_W; i++) begin
      if (absErr[i]) errPos = POS_W'(WORD_W - 1 - i);
    end
  end

  // Capture stage.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pendCycle <= '0;
      pendPos   <= '0;
    end else if (strobe.capture) begin
      pendCycle <= inCycle;
      pendPos   <= errPos;
    end
  end

  // One row of bins and a minimum tracker per cycle index.
  for (genvar c = 0; c < CYC_N; c++) begin : g_row
    logic [NBIN-1:0][CNT_W-1:0] rowBins;
    logic [POS_W-1:0]           rowMin;
    logic                       rowHit;

    assign rowHit = strobe.update && (pendCycle == CYC_W'(c));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rowBins <= '0;
        rowMin  <= POS_EMPTY;
      end else if (strobe.clearAll) begin
        rowBins <= '0;
        rowMin  <= POS_EMPTY;
      end else if (rowHit) begin
        for (int p = 0; p < NBIN; p++) begin
          if (pendPos == POS_W'(p) && rowBins[p] != '1)
            rowBins[p] <= rowBins[p] + 1'b1;
        end
        if (pendPos < rowMin) rowMin <= pendPos;
      end
    end

    assign binFlat[c] = rowBins;
    assign minFlat[c] = rowMin;
  end

  // Read mux, registered.
  logic [CNT_W-1:0] rdCountNext;
  logic [POS_W-1:0] rdMinNext;

  always_comb begin
    rdCountNext = '0;
    rdMinNext   = POS_EMPTY;
    for (int c = 0; c < CYC_N; c++) begin
      if (rdCycle == CYC_W'(c)) begin
        rdMinNext = minFlat[c];
        for (int p = 0; p < NBIN; p++) begin
          if (rdPos == POS_W'(p)) rdCountNext = binFlat[c][p];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdCount <= '0;
      rdMin   <= POS_EMPTY;
    end else begin
      rdCount <= rdCountNext;
      rdMin   <= rdMinNext;
    end
  end
endmodule

// File: rtl/feb_hist.sv
module feb_hist
  import feb_hist_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CYC_N  = 50,
  localparam int CYC_W = (CYC_N > 1) ? $clog2(CYC_N) : 1,
  localparam int POS_W = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              inValid,
  input  logic [CYC_W-1:0]  inCycle,
  input  logic [WORD_W-1:0] inEstimate,
  input  logic [WORD_W-1:0] inReference,
  input  logic [CYC_W-1:0]  rdCycle,
  input  logic [POS_W-1:0]  rdPos,
  output logic [15:0]       rdCount,
  output logic [POS_W-1:0]  rdMin
);
  febStrobeT strobe;

  feb_hist_ctrl #(.CYC_N(CYC_N), .CYC_W(CYC_W)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (clear),
    .inValid (inValid),
    .inCycle (inCycle),
    .strobe  (strobe)
  );

  feb_hist_dp #(.WORD_W(WORD_W), .CYC_N(CYC_N), .CYC_W(CYC_W), .POS_W(POS_W)) u_dp (
    .clk         (clk),
    .rst_n       (rst_n),
    .strobe      (strobe),
    .inCycle     (inCycle),
    .inEstimate  (inEstimate),
    .inReference (inReference),
    .rdCycle     (rdCycle),
    .rdPos       (rdPos),
    .rdCount     (rdCount),
    .rdMin       (rdMin)
  );
endmodule

// File: rtl/feb_hist_chk.sv
module feb_hist_chk #(
  parameter int WORD_W = 16,
  parameter int CYC_N  = 50,
  parameter int CYC_W  = 6,
  parameter int POS_W  = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clear,
  input logic [CYC_W-1:0] rdCycle,
  input logic [POS_W-1:0] rdPos,
  input logic [15:0]      rdCount,
  input logic [POS_W-1:0] rdMin
);
  localparam logic [POS_W-1:0] POS_EMPTY = POS_W'(WORD_W);
  localparam logic [CYC_W:0]   CYC_LIM   = (CYC_W+1)'(CYC_N);

  // R5: a minimum never exceeds the empty marker.
  p_min_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rdMin <= POS_EMPTY);

  // R6: two edges after a clear the read port shows an empty bin and an empty minimum.
  p_clear_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clear |-> ##2 (rdCount == 16'd0 && rdMin == POS_EMPTY));

  // R4: with a fixed address and no clear, a count grows by at most one and never wraps.
  p_count_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !$past(clear) && $stable(rdCycle) && $stable(rdPos)) |=>
      (rdCount == $past(rdCount) ||
       {1'b0, rdCount} == {1'b0, $past(rdCount)} + 17'd1));

  // R5: with a fixed address and no clear, a minimum never rises.
  p_min_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && !$past(clear) && $stable(rdCycle)) |=> rdMin <= $past(rdMin));

  // R8: reads outside the cycle range give an empty result one cycle later.
  p_oor_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ({1'b0, rdCycle} >= CYC_LIM) |=> (rdCount == 16'd0 && rdMin == POS_EMPTY));
endmodule

bind feb_hist feb_hist_chk #(
  .WORD_W (WORD_W),
  .CYC_N  (CYC_N),
  .CYC_W  (CYC_W),
  .POS_W  (POS_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clear   (clear),
  .rdCycle (rdCycle),
  .rdPos   (rdPos),
  .rdCount (rdCount),
  .rdMin   (rdMin)
);

// File: tb/feb_hist_tb.sv
module feb_hist_tb;
  localparam int W   = 4;
  localparam int C   = 3;
  localparam int CW  = 2;
  localparam int PW  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clear = 1'b0;
  logic          inValid = 1'b0;
  logic [CW-1:0] inCycle = '0;
  logic [W-1:0]  inEstimate = '0;
  logic [W-1:0]  inReference = '0;
  logic [CW-1:0] rdCycle = '0;
  logic [PW-1:0] rdPos = '0;
  logic [15:0]   rdCount;
  logic [PW-1:0] rdMin;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  int expCnt [C][W+1];
  int expMin [C];

  always #2.5 clk = ~clk;

  feb_hist #(.WORD_W(W), .CYC_N(C)) u_dut (
    .clk(clk), .rst_n(rst_n), .clear(clear), .inValid(inValid),
    .inCycle(inCycle), .inEstimate(inEstimate), .inReference(inReference),
    .rdCycle(rdCycle), .rdPos(rdPos), .rdCount(rdCount), .rdMin(rdMin)
  );

  function automatic int expPos(input int e);
    int v = e;
    int n = 0;
    while (v > 0) begin
      v = v >> 1;
      n++;
    end
    return W - n;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic modelClear();
    for (int c = 0; c < C; c++) begin
      for (int p = 0; p <= W; p++) expCnt[c][p] = 0;
      expMin[c] = W;
    end
  endtask

  task automatic send(input int c, input int est, input int rf);
    inValid = 1'b1;
    inCycle = CW'(c);
    inEstimate = W'(est);
    inReference = W'(rf);
    @(negedge clk);
    if (c < C) begin
      int e = (est >= rf) ? est - rf : rf - est;
      int p = expPos(e);
      if (expCnt[c][p] < 65535) expCnt[c][p]++;
      if (p < expMin[c]) expMin[c] = p;
    end
  endtask

  task automatic idle(input int n);
    inValid = 1'b0;
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic pulseClear();
    inValid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    modelClear();
    idle(2);
  endtask

  task automatic readBin(input int c, input int p, output int cnt, output int mn);
    rdCycle = CW'(c);
    rdPos = PW'(p);
    @(negedge clk);
    cnt = int'(rdCount);
    mn = int'(rdMin);
  endtask

  task automatic compareAll(input string tag);
    int cnt, mn;
    for (int c = 0; c < C; c++) begin
      for (int p = 0; p <= W; p++) begin
        readBin(c, p, cnt, mn);
        check(cnt == expCnt[c][p], {tag, " bin count"}, cnt, expCnt[c][p]);
      end
      check(mn == expMin[c], {"R5 ", tag, " minimum"}, mn, expMin[c]);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt, mn, total;
    modelClear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    compareAll("R9 reset");

    // R1 R2 R3 R7: back-to-back sweep of all operand pairs, including an out-of-range cycle
    for (int c = 0; c <= C; c++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          send(c, a, b);
    idle(2);
    compareAll("R1 R2 R3 sweep");
    total = 0;
    for (int c = 0; c < C; c++)
      for (int p = 0; p <= W; p++) begin
        readBin(c, p, cnt, mn);
        total += cnt;
      end
    check(total == C * 256, "R7 total excludes out-of-range cycle", total, C * 256);

    // R8: out-of-range read addresses
    readBin(3, 0, cnt, mn);
    check(cnt == 0, "R8 out-of-range cycle count", cnt, 0);
    check(mn == W, "R8 out-of-range cycle minimum", mn, W);
    readBin(0, 6, cnt, mn);
    check(cnt == 0, "R8 out-of-range position count", cnt, 0);

    // R6: clear empties everything
    pulseClear();
    compareAll("R6 after clear");

    // R3: latency of one sample
    rdCycle = CW'(1);
    rdPos = PW'(2);
    send(1, 2, 0);
    inValid = 1'b0;
    check(rdCount == 16'd0, "R3 latency first edge", int'(rdCount), 0);
    @(negedge clk);
    check(rdCount == 16'd0, "R3 latency second edge", int'(rdCount), 0);
    @(negedge clk);
    check(rdCount == 16'd1, "R3 latency third edge", int'(rdCount), 1);

    // R5: minimum tracking
    send(1, 0, 1);
    send(1, 4, 0);
    send(1, 0, 2);
    send(2, 3, 3);
    idle(2);
    readBin(1, 0, cnt, mn);
    check(mn == 1, "R5 minimum of cycle one", mn, 1);
    readBin(2, 0, cnt, mn);
    check(mn == W, "R5 zero error leaves minimum at width", mn, W);
    send(2, 15, 7);
    idle(2);
    readBin(2, 0, cnt, mn);
    check(mn == 0 && cnt == 1, "R2 MSB error position zero", mn, 0);

    // R6: drop rules around clear
    pulseClear();
    inValid = 1'b1; inCycle = '0; inEstimate = W'(5); inReference = W'(5);
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    idle(2);
    readBin(0, W, cnt, mn);
    check(cnt == 0, "R6 samples at and before clear dropped", cnt, 0);
    check(mn == W, "R6 minimum untouched by dropped samples", mn, W);
    send(0, 5, 5);
    idle(2);
    readBin(0, W, cnt, mn);
    check(cnt == 1, "R6 sample after clear counted", cnt, 1);

    // R4: saturation
    pulseClear();
    for (int i = 0; i < 65540; i++) send(2, 9, 9);
    idle(2);
    readBin(2, W, cnt, mn);
    check(cnt == 65535, "R4 saturated count", cnt, 65535);
    readBin(2, 0, cnt, mn);
    check(cnt == 0, "R4 neighbour bin untouched", cnt, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule